// File: doc/BRIEF.md
# Prediction Coefficient Generator

This unit prepares the key-dependent coefficient matrix that a concurrent error checker for a GF(2^128) hash multiplier needs. When a start strobe is accepted it loads the hash key H and walks the chain Z(0) = H, Z(j) = Z(j-1)·x reduced modulo x^128 + x^7 + x^2 + x + 1. This gives one field element per cycle. For each element it produces the remainder of Z(j) divided by a degree-K check polynomial g(x), and stores that K-bit remainder as column j of K row vectors, each 128 bits wide.

The first remainder comes from a full fold of H. Every later remainder comes from the previous one through a small constant update driven by the bit that leaves the top of Z. With K = 1 and g(x) = x + 1 the rows reduce to the parity of every Z(j). After 128 run cycles the matrix stays unchanged for the whole authentication pass that follows, until the next accepted start.

Top module: `ppc_coef_gen`

## Requirements
- R1: After reset, done_o is low and every bit of coef_o is zero.
- R2: Column 0 of row i (bit i*128 + 0 of coef_o) equals bit i of H mod g(x). With K = 1 this is the parity of H.
- R3: Column j of row i (bit i*128 + j of coef_o) equals bit i of Z(j) mod g(x). Z(j) is H·x^j. One step shifts the element left by one bit and XORs 0x87 into the low byte when the bit shifted out of position 127 was 1.
- R4: g(x) = x^K + CRC_POLY, where bit b of CRC_POLY is the coefficient of x^b. Bit i of a remainder is its x^i coefficient. With K = 1 and CRC_POLY = 1, row 0 holds parity(Z(j)), which changes from j-1 to j exactly when bit 127 of Z(j-1) was 1.
- R5: done_o is high for exactly one cycle, 128 clock cycles after the edge that accepts start_i, and is low at all other times.
- R6: start_i is ignored while a run is in progress. Neither the key nor the timing of that run changes.
- R7: Outside a run, coef_o holds its value until the next accepted start.
- R8: A start_i that is high in the cycle where done_o is high is accepted, and a new run begins on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| key_i | input | FIELD_W | Hash key H, sampled with an accepted start |
| done_o | output | 1 | One-cycle pulse when the matrix is complete |
| coef_o | output | CRC_BITS*FIELD_W | Row i at bits [i*FIELD_W +: FIELD_W]; bit j of a row is column j |

## Verification
The accepting edge counts as cycle 0. Every column is shifted in on the following edges, so both the complete matrix and done_o are due in the cycle after edge 128, and no result exists earlier. The bench model samples start_i and key_i on the same rising edge as the design and advances its own run counter on each edge. It compares done_o with the model on every falling edge. In the model's done cycle it compares the matrix with a long-division reference. After that it rechecks the stored expectation on every idle cycle. Three instances with K = 4, 3 and 1 share the stimulus, and the stimulus includes keys that overflow on the first step, a zero key, a start during a run, and a start held across done.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic {GEN_IDLE, GEN_RUN} gen_state_e;
  localparam int unsigned FIELD_W_DEF = 128;
endpackage

// File: rtl/ppc_alpha_step.sv
module ppc_alpha_step #(
  parameter int unsigned W = 128,
  parameter logic [W-1:0] RED_POLY = 'h87
) (
  input  logic [W-1:0] z_i,
  output logic [W-1:0] z_o,
  output logic         carry_o
);
  assign carry_o = z_i[W-1];
  assign z_o     = {z_i[W-2:0], 1'b0} ^ (z_i[W-1] ? RED_POLY : '0);
endmodule

// File: rtl/ppc_crc_fold.sv
module ppc_crc_fold #(
  parameter int unsigned W = 128,
  parameter int unsigned K = 4,
  parameter logic [K-1:0] POLY = 'h3
) (
  input  logic [W-1:0] v_i,
  output logic [K-1:0] rem_o
);
  function automatic logic [K-1:0] mulx(input logic [K-1:0] r);
    return (r << 1) ^ (r[K-1] ? POLY : '0);
  endfunction

  logic [K-1:0] acc [W+1];
  assign acc[W] = '0;

  // Horner from the top coefficient down
  for (genvar b = W - 1; b >= 0; b--) begin : g_stage
    assign acc[b] = mulx(acc[b+1]) ^ K'(v_i[b]);
  end

  assign rem_o = acc[0];
endmodule

// File: rtl/ppc_crc_step.sv
module ppc_crc_step #(
  parameter int unsigned W = 128,
  parameter int unsigned K = 4,
  parameter logic [K-1:0] POLY = 'h3,
  parameter logic [W-1:0] RED_POLY = 'h87
) (
  input  logic [K-1:0] rem_i,
  input  logic         carry_i,
  output logic [K-1:0] rem_o
);
  function automatic logic [K-1:0] mulx(input logic [K-1:0] r);
    return (r << 1) ^ (r[K-1] ? POLY : '0);
  endfunction

  // field polynomial x^W + RED_POLY reduced mod g
  function automatic logic [K-1:0] field_rem();
    logic [K-1:0] r;
    r = K'(1);
    for (int b = W - 1; b >= 0; b--) r = mulx(r) ^ K'(RED_POLY[b]);
    return r;
  endfunction

  localparam logic [K-1:0] F_REM = field_rem();

  assign rem_o = mulx(rem_i) ^ (carry_i ? F_REM : '0);
endmodule

// File: rtl/ppc_col_store.sv
module ppc_col_store #(
  parameter int unsigned W = 128,
  parameter int unsigned K = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_i,
  input  logic [K-1:0]   col_i,
  output logic [K*W-1:0] coef_o
);
  for (genvar i = 0; i < K; i++) begin : g_row
    logic [W-1:0] row_q;
    // column j enters at the top and lands at bit j after the last shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      row_q <= '0;
      else if (shift_i) row_q <= {col_i[i], row_q[W-1:1]};
    end
    assign coef_o[i*W +: W] = row_q;
  end
endmodule

// File: rtl/ppc_coef_gen.sv
module ppc_coef_gen
  import ppc_pkg::*;
#(
  parameter int unsigned FIELD_W = FIELD_W_DEF,
  parameter int unsigned CRC_BITS = 4,
  parameter logic [CRC_BITS-1:0] CRC_POLY = 'h3,
  parameter logic [FIELD_W-1:0] RED_POLY = 'h87
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [FIELD_W-1:0]        key_i,
  output logic                      done_o,
  output logic [CRC_BITS*FIELD_W-1:0] coef_o
);
  localparam int unsigned CW = $clog2(FIELD_W);
  localparam logic [CW-1:0] LAST = CW'(FIELD_W - 1);

  gen_state_e           state_q;
  logic [CW-1:0]        cnt_q;
  logic [FIELD_W-1:0]   z_q, z_nxt;
  logic [CRC_BITS-1:0]  rem_q, rem_nxt, rem_key;
  logic                 carry;
  logic                 done_q;
  logic                 run, accept;

  assign run    = (state_q == GEN_RUN);
  assign accept = !run && start_i;

  ppc_alpha_step #(.W(FIELD_W), .RED_POLY(RED_POLY)) u_alpha (
    .z_i(z_q), .z_o(z_nxt), .carry_o(carry)
  );

  ppc_crc_fold #(.W(FIELD_W), .K(CRC_BITS), .POLY(CRC_POLY)) u_fold (
    .v_i(key_i), .rem_o(rem_key)
  );

  ppc_crc_step #(.W(FIELD_W), .K(CRC_BITS), .POLY(CRC_POLY), .RED_POLY(RED_POLY)) u_step (
    .rem_i(rem_q), .carry_i(carry), .rem_o(rem_nxt)
  );

  ppc_col_store #(.W(FIELD_W), .K(CRC_BITS)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(run), .col_i(rem_q), .coef_o(coef_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GEN_IDLE;
      cnt_q   <= '0;
      z_q     <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= GEN_RUN;
        cnt_q   <= '0;
        z_q     <= key_i;
        rem_q   <= rem_key;
      end else if (run) begin
        z_q   <= z_nxt;
        rem_q <= rem_nxt;
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          state_q <= GEN_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(run && cnt_q == LAST));

  // R6
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && start_i && cnt_q != LAST) |=> (run && cnt_q == $past(cnt_q) + CW'(1)));

  // R7
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(coef_o));
endmodule

// File: tb/ppc_coef_gen_test.sv
module ppc_coef_gen_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start = 1'b0;
  logic [127:0] key = '0;
  logic         done4, done3, done1;
  logic [511:0] coef4;
  logic [383:0] coef3;
  logic [127:0] coef1;

  int tests = 0;
  int fails = 0;
  string tag_run = "R3";

  always #5 clk = ~clk;

  ppc_coef_gen #(.CRC_BITS(4), .CRC_POLY(4'b0011)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .key_i(key), .done_o(done4), .coef_o(coef4));
  ppc_coef_gen #(.CRC_BITS(3), .CRC_POLY(3'b011)) uut_k3 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .key_i(key), .done_o(done3), .coef_o(coef3));
  ppc_coef_gen #(.CRC_BITS(1), .CRC_POLY(1'b1)) uut_k1 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .key_i(key), .done_o(done1), .coef_o(coef1));

  // long division of every H*x^j by g = x^k + poly
  function automatic logic [127:0] ref_row(input logic [127:0] h, input int k, input int poly, input int row);
    logic [127:0] z;
    logic [127:0] res;
    logic [135:0] work;
    logic [135:0] g;
    z = h;
    res = '0;
    g = 136'((1 << k) | poly);
    for (int j = 0; j < 128; j++) begin
      work = {8'b0, z};
      for (int b = 127; b >= k; b--) if (work[b]) work = work ^ (g << (b - k));
      res[j] = work[row];
      z = z[127] ? ((z << 1) ^ 128'h87) : (z << 1);
    end
    return res;
  endfunction

  task automatic check(input string req, input string what, input logic [127:0] got, input logic [127:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // cycle model
  logic         m_busy = 1'b0, m_done = 1'b0, m_have = 1'b0;
  int           m_cnt = 0;
  logic [127:0] m_h = '0;
  logic [127:0] e4 [4];
  logic [127:0] e3 [3];
  logic [127:0] e1;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start) begin
        m_busy <= 1'b1; m_cnt <= 0; m_h <= key;
      end else if (m_busy) begin
        m_cnt <= m_cnt + 1;
        if (m_cnt == 127) begin
          m_busy <= 1'b0; m_done <= 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      // R5 done compared every cycle
      check("R5", "done k4", 128'(done4), 128'(m_done));
      check("R5", "done k3", 128'(done3), 128'(m_done));
      check("R5", "done k1", 128'(done1), 128'(m_done));
      if (m_done) begin
        for (int i = 0; i < 4; i++) e4[i] = ref_row(m_h, 4, 3, i);
        for (int i = 0; i < 3; i++) e3[i] = ref_row(m_h, 3, 3, i);
        e1 = ref_row(m_h, 1, 1, 0);
        m_have = 1'b1;
        for (int i = 0; i < 4; i++) check(tag_run, $sformatf("k4 row %0d", i), coef4[i*128 +: 128], e4[i]);
        for (int i = 0; i < 3; i++) check(tag_run, $sformatf("k3 row %0d", i), coef3[i*128 +: 128], e3[i]);
        check("R4", "k1 parity row", coef1, e1);
        check("R2", "k1 column 0 parity of H", 128'(coef1[0]), 128'(^m_h));
        check("R2", "k4 column 0", 128'({coef4[384], coef4[256], coef4[128], coef4[0]}),
              128'({e4[3][0], e4[2][0], e4[1][0], e4[0][0]}));
      end else if (m_have && !m_busy) begin
        for (int i = 0; i < 4; i++) check("R7", $sformatf("k4 hold row %0d", i), coef4[i*128 +: 128], e4[i]);
        check("R7", "k1 hold", coef1, e1);
      end
    end
  end

  task automatic run_key(input logic [127:0] h, input string tg);
    @(negedge clk);
    tag_run = tg;
    key = h;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    key = ~h;
    wait (m_done);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "done k4 in reset", 128'(done4), '0);
    check("R1", "coef k4 in reset", coef4[127:0] | coef4[255:128] | coef4[383:256] | coef4[511:384], '0);
    check("R1", "coef k1 in reset", coef1, '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "done k1 after reset", 128'(done1), '0);

    run_key({$urandom, $urandom, $urandom, $urandom}, "R3");
    run_key({$urandom, $urandom, $urandom, $urandom}, "R3");
    run_key(128'h8000_0000_0000_0000_0000_0000_0000_0001, "R3");
    run_key(128'h1, "R3");
    run_key('1, "R3");
    run_key('0, "R3");

    // R6: second start mid-run with a different key
    @(negedge clk);
    tag_run = "R6";
    key = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    key = {$urandom, $urandom, $urandom, $urandom};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (m_done);
    repeat (4) @(negedge clk);

    // R8: start held through done restarts with the new key
    @(negedge clk);
    tag_run = "R8";
    key = {$urandom, $urandom, $urandom, $urandom};
    start = 1'b1;
    @(negedge clk);
    key = {$urandom, $urandom, $urandom, $urandom};
    wait (m_done);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    tests++;
    if (!m_busy) begin
      fails++;
      $display("FAIL R8 restart: got idle expected new run");
    end
    wait (m_done);
    repeat (6) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule